// File: doc/BRIEF.md
# Cartridge Bank Control Register

This block holds the one-byte control value of a bank-switched expansion cartridge. The CPU loads it by writing anywhere in the first expansion I/O page. The byte sets the two cartridge configuration lines that go to the system memory decoder. It picks one of four 8 KB banks of low-window ROM. It can also map an 8 KB cartridge RAM over the low window in place of the ROM.

For every cartridge access, the block turns the access region and the low address bits into a chip select and a byte address. The ROM select and address go to a 32 KB cartridge ROM, and the RAM select, write enable and address go to the 8 KB cartridge RAM. Three regions are mapped this way: the low ROM window, the high ROM window and the second expansion I/O page. The second page shows the last 256 bytes of the selected ROM bank, or of the RAM when RAM substitution is on.

Three request inputs load fixed control values when the freeze button is pressed, when the cartridge is detached and when it is attached. Reset loads the same value as attach. Writing a byte with bit 6 set also issues a one-cycle release pulse to the freeze logic.

Top module: `cart_bank_ctl`

## Requirements
- R1: While and after reset the control value is 0, so game is 0, exrom is 1 and freeze_release is 0.
- R2: A write in the first I/O page (acc_region = 3, acc_wr = 1) loads wr_data at the clock edge. From then on, game equals bit 0 and exrom equals the inverse of bit 1.
- R3: Such a write with bit 6 set drives freeze_release high for exactly the one cycle after the edge. A write that loses to a load request gives no pulse.
- R4: A low-window read (acc_region = 1, acc_rd = 1) with bit 5 clear asserts rom_cs with rom_addr = bank*0x2000 + acc_addr[12:0]. The bank is control bits 4:3.
- R5: A low-window read with bit 5 set asserts ram_cs with ram_addr = acc_addr[12:0], and rom_cs stays low.
- R6: A low-window write asserts ram_cs and ram_we at acc_addr[12:0] only when bit 5 is set. Otherwise no select or write enable is raised.
- R7: A read in the second I/O page (acc_region = 4) uses only acc_addr[7:0]. With bit 5 set it reads RAM at 0x1F00 + acc_addr[7:0]. With bit 5 clear it reads ROM at bank*0x2000 + 0x1F00 + acc_addr[7:0].
- R8: A write in the second I/O page writes RAM at 0x1F00 + acc_addr[7:0] only when bit 5 is set. Otherwise it raises nothing.
- R9: A high-window read (acc_region = 2) asserts rom_cs at acc_addr[12:0] whatever the bank. A high-window write raises no select.
- R10: A read in the first I/O page raises no select and leaves rd_valid low, so the data is open bus.
- R11: freeze_req loads 35, detach_req loads 6 and attach_req loads 0. When several requests or a CPU write fall in the same cycle, the priority is freeze, then detach, then attach, then the CPU write.
- R12: rd_valid is high exactly when a read selects the ROM or the RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_region | input | 3 | Region of the access: 0 none, 1 low window, 2 high window, 3 first I/O page, 4 second I/O page |
| acc_rd | input | 1 | Read strobe |
| acc_wr | input | 1 | Write strobe |
| acc_addr | input | 13 | Low address bits of the access |
| wr_data | input | 8 | CPU write data |
| freeze_req | input | 1 | Freeze button pressed (already debounced) |
| detach_req | input | 1 | Cartridge detach |
| attach_req | input | 1 | Cartridge attach |
| game | output | 1 | Configuration line, control bit 0 |
| exrom | output | 1 | Configuration line, inverse of control bit 1 |
| freeze_release | output | 1 | One-cycle release pulse to the freeze logic |
| rom_cs | output | 1 | Cartridge ROM select |
| rom_addr | output | 15 | Cartridge ROM byte address (0 when not selected) |
| ram_cs | output | 1 | Cartridge RAM select |
| ram_we | output | 1 | Cartridge RAM write enable |
| ram_addr | output | 13 | Cartridge RAM byte address (0 when not selected) |
| rd_valid | output | 1 | Read data comes from ROM or RAM |

## Verification
The assertions assume that acc_rd and acc_wr are never high together and that acc_region carries only the five listed codes. The bench keeps to this: every access raises one strobe against one valid region, and the strobes are dropped between accesses. Inputs change only on the falling clock edge, so each load request and control write is seen at exactly one rising edge.

// File: rtl/cbk_pkg.sv
package cbk_pkg;
  localparam int unsigned MODE_W = 8;

  // access region codes seen on acc_region
  typedef enum logic [2:0] {
    RGN_NONE = 3'd0,
    RGN_LOW  = 3'd1,
    RGN_HIGH = 3'd2,
    RGN_IO1  = 3'd3,
    RGN_IO2  = 3'd4
  } region_e;

  // control byte field positions
  localparam int unsigned BIT_GAME    = 0;
  localparam int unsigned BIT_EXROM_N = 1;
  localparam int unsigned BIT_BANK_LO = 3;
  localparam int unsigned BIT_RAM     = 5;
  localparam int unsigned BIT_RELEASE = 6;

  // fixed load values
  localparam logic [MODE_W-1:0] MODE_FREEZE = 8'd35;
  localparam logic [MODE_W-1:0] MODE_DETACH = 8'd6;
  localparam logic [MODE_W-1:0] MODE_ATTACH = 8'd0;
endpackage

// File: rtl/cbk_mode_reg.sv
module cbk_mode_reg
  import cbk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              freeze_req,
  input  logic              detach_req,
  input  logic              attach_req,
  input  logic              cpu_wr,
  input  logic [MODE_W-1:0] cpu_data,
  output logic [MODE_W-1:0] mode_q,
  output logic              release_q
);
  logic [MODE_W-1:0] mode_d;
  logic              mode_en;
  logic              release_d;
  logic              cpu_taken;

  always_comb begin
    cpu_taken = cpu_wr && !freeze_req && !detach_req && !attach_req;
    mode_en   = freeze_req || detach_req || attach_req || cpu_wr;
    if (freeze_req)      mode_d = MODE_FREEZE;
    else if (detach_req) mode_d = MODE_DETACH;
    else if (attach_req) mode_d = MODE_ATTACH;
    else                 mode_d = cpu_data;
    release_d = cpu_taken && cpu_data[BIT_RELEASE];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_ATTACH;
    end else if (mode_en) begin
      mode_q <= mode_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      release_q <= 1'b0;
    end else begin
      release_q <= release_d;
    end
  end
endmodule

// File: rtl/cbk_mode_decode.sv
module cbk_mode_decode
  import cbk_pkg::*;
#(
  parameter int unsigned BANK_BITS = 2
) (
  input  logic [MODE_W-1:0]    mode,
  output logic                 game,
  output logic                 exrom,
  output logic [BANK_BITS-1:0] bank,
  output logic                 ram_sel
);
  always_comb begin
    game    = mode[BIT_GAME];
    exrom   = !mode[BIT_EXROM_N];
    bank    = mode[BIT_BANK_LO +: BANK_BITS];
    ram_sel = mode[BIT_RAM];
  end
endmodule

// File: rtl/cbk_addr_map.sv
module cbk_addr_map
  import cbk_pkg::*;
#(
  parameter int unsigned BANK_BITS = 2,
  parameter int unsigned BANK_AW   = 13,
  parameter int unsigned PAGE_AW   = 8
) (
  input  logic [2:0]                   region,
  input  logic                         rd,
  input  logic                         wr,
  input  logic [BANK_AW-1:0]           addr,
  input  logic [BANK_BITS-1:0]         bank,
  input  logic                         ram_sel,
  output logic                         rom_cs,
  output logic [BANK_BITS+BANK_AW-1:0] rom_addr,
  output logic                         ram_cs,
  output logic                         ram_we,
  output logic [BANK_AW-1:0]           ram_addr,
  output logic                         rd_valid
);
  localparam int unsigned ROM_AW = BANK_BITS + BANK_AW;
  localparam int unsigned TOP_W  = BANK_AW - PAGE_AW;

  logic [BANK_AW-1:0] win_off;

  // offset of the last page of a bank for the second I/O page window
  generate
    if (TOP_W > 0) begin : g_win
      assign win_off = {{TOP_W{1'b1}}, addr[PAGE_AW-1:0]};
    end else begin : g_flat
      assign win_off = addr;
    end
  endgenerate

  always_comb begin
    rom_cs   = 1'b0;
    rom_addr = '0;
    ram_cs   = 1'b0;
    ram_we   = 1'b0;
    ram_addr = '0;
    unique case (region)
      RGN_LOW: begin
        if (ram_sel && (rd || wr)) begin
          ram_cs   = 1'b1;
          ram_we   = wr;
          ram_addr = addr;
        end else if (rd) begin
          rom_cs   = 1'b1;
          rom_addr = {bank, addr};
        end
      end
      RGN_HIGH: begin
        if (rd) begin
          rom_cs   = 1'b1;
          rom_addr = {{BANK_BITS{1'b0}}, addr};
        end
      end
      RGN_IO2: begin
        if (ram_sel && (rd || wr)) begin
          ram_cs   = 1'b1;
          ram_we   = wr;
          ram_addr = win_off;
        end else if (rd) begin
          rom_cs   = 1'b1;
          rom_addr = {bank, win_off};
        end
      end
      default: begin
      end
    endcase
    rd_valid = rd && (rom_cs || ram_cs);
  end

  logic unused_w;
  assign unused_w = (ROM_AW == 0);
endmodule

// File: rtl/cart_bank_ctl.sv
module cart_bank_ctl
  import cbk_pkg::*;
#(
  parameter int unsigned ROM_BANKS = 4,
  parameter int unsigned BANK_AW   = 13,
  parameter int unsigned PAGE_AW   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2:0]           acc_region,
  input  logic                 acc_rd,
  input  logic                 acc_wr,
  input  logic [12:0]          acc_addr,
  input  logic [7:0]           wr_data,
  input  logic                 freeze_req,
  input  logic                 detach_req,
  input  logic                 attach_req,
  output logic                 game,
  output logic                 exrom,
  output logic                 freeze_release,
  output logic                 rom_cs,
  output logic [14:0]          rom_addr,
  output logic                 ram_cs,
  output logic                 ram_we,
  output logic [12:0]          ram_addr,
  output logic                 rd_valid
);
  localparam int unsigned BANK_BITS = $clog2(ROM_BANKS);

  logic [MODE_W-1:0]    mode_q;
  logic [BANK_BITS-1:0] bank;
  logic                 ram_sel;
  logic                 cpu_wr;

  assign cpu_wr = acc_wr && (acc_region == RGN_IO1);

  cbk_mode_reg u_reg (
    .clk        (clk),
    .rst_n      (rst_n),
    .freeze_req (freeze_req),
    .detach_req (detach_req),
    .attach_req (attach_req),
    .cpu_wr     (cpu_wr),
    .cpu_data   (wr_data),
    .mode_q     (mode_q),
    .release_q  (freeze_release)
  );

  cbk_mode_decode #(.BANK_BITS(BANK_BITS)) u_dec (
    .mode    (mode_q),
    .game    (game),
    .exrom   (exrom),
    .bank    (bank),
    .ram_sel (ram_sel)
  );

  cbk_addr_map #(
    .BANK_BITS (BANK_BITS),
    .BANK_AW   (BANK_AW),
    .PAGE_AW   (PAGE_AW)
  ) u_map (
    .region   (acc_region),
    .rd       (acc_rd),
    .wr       (acc_wr),
    .addr     (acc_addr),
    .bank     (bank),
    .ram_sel  (ram_sel),
    .rom_cs   (rom_cs),
    .rom_addr (rom_addr),
    .ram_cs   (ram_cs),
    .ram_we   (ram_we),
    .ram_addr (ram_addr),
    .rd_valid (rd_valid)
  );
endmodule

// File: rtl/cbk_checker.sv
module cbk_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  acc_region,
  input logic        acc_rd,
  input logic        acc_wr,
  input logic [12:0] acc_addr,
  input logic [7:0]  wr_data,
  input logic        freeze_req,
  input logic        detach_req,
  input logic        attach_req,
  input logic        game,
  input logic        exrom,
  input logic        freeze_release,
  input logic        rom_cs,
  input logic [14:0] rom_addr,
  input logic        ram_cs,
  input logic        ram_we,
  input logic        rd_valid
);
  logic plain_wr;
  assign plain_wr = acc_wr && (acc_region == 3'd3) && !freeze_req && !detach_req && !attach_req;

  a_r2_decode: assert property (@(posedge clk) disable iff (!rst_n)
    plain_wr |=> (game == $past(wr_data[0])) && (exrom == !$past(wr_data[1])));

  a_r3_release_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(freeze_release) |-> $past(plain_wr && wr_data[6]));

  a_r11_freeze_load: assert property (@(posedge clk) disable iff (!rst_n)
    freeze_req |=> (game && !exrom && !freeze_release));

  a_r11_attach_load: assert property (@(posedge clk) disable iff (!rst_n)
    (attach_req && !freeze_req && !detach_req) |=> (!game && exrom));

  a_r6_we_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (ram_cs && acc_wr));

  a_r9_high_bank0: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_region == 3'd2 && acc_rd) |-> (rom_cs && rom_addr[14:13] == 2'b00 && rom_addr[12:0] == acc_addr));

  a_r10_io1_open: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_region == 3'd3) |-> (!rom_cs && !ram_cs && !rd_valid));

  a_r12_valid_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (acc_rd && (rom_cs ^ ram_cs)));
endmodule

bind cart_bank_ctl cbk_checker u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .acc_region     (acc_region),
  .acc_rd         (acc_rd),
  .acc_wr         (acc_wr),
  .acc_addr       (acc_addr),
  .wr_data        (wr_data),
  .freeze_req     (freeze_req),
  .detach_req     (detach_req),
  .attach_req     (attach_req),
  .game           (game),
  .exrom          (exrom),
  .freeze_release (freeze_release),
  .rom_cs         (rom_cs),
  .rom_addr       (rom_addr),
  .ram_cs         (ram_cs),
  .ram_we         (ram_we),
  .rd_valid       (rd_valid)
);

// File: tb/sim_cart_bank_ctl.sv
module sim_cart_bank_ctl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  acc_region;
  logic        acc_rd, acc_wr;
  logic [12:0] acc_addr;
  logic [7:0]  wr_data;
  logic        freeze_req, detach_req, attach_req;
  logic        game, exrom, freeze_release;
  logic        rom_cs, ram_cs, ram_we, rd_valid;
  logic [14:0] rom_addr;
  logic [12:0] ram_addr;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cart_bank_ctl u0 (
    .clk(clk), .rst_n(rst_n), .acc_region(acc_region), .acc_rd(acc_rd),
    .acc_wr(acc_wr), .acc_addr(acc_addr), .wr_data(wr_data),
    .freeze_req(freeze_req), .detach_req(detach_req), .attach_req(attach_req),
    .game(game), .exrom(exrom), .freeze_release(freeze_release),
    .rom_cs(rom_cs), .rom_addr(rom_addr), .ram_cs(ram_cs), .ram_we(ram_we),
    .ram_addr(ram_addr), .rd_valid(rd_valid)
  );

  // vector: mode, region, rd, wr, addr, rom_cs, rom_addr, ram_cs, ram_we, ram_addr, rd_valid
  typedef struct packed {
    logic [7:0]  mode;
    logic [2:0]  rgn;
    logic        rd;
    logic        wr;
    logic [12:0] addr;
    logic        e_rom;
    logic [14:0] e_rom_addr;
    logic        e_ram;
    logic        e_we;
    logic [12:0] e_ram_addr;
    logic        e_valid;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{8'h00, 3'd1, 1'b1, 1'b0, 13'h0123, 1'b1, 15'h0123, 1'b0, 1'b0, 13'h0000, 1'b1},
    '{8'h08, 3'd1, 1'b1, 1'b0, 13'h1FFF, 1'b1, 15'h3FFF, 1'b0, 1'b0, 13'h0000, 1'b1},
    '{8'h10, 3'd1, 1'b1, 1'b0, 13'h0000, 1'b1, 15'h4000, 1'b0, 1'b0, 13'h0000, 1'b1},
    '{8'h18, 3'd1, 1'b1, 1'b0, 13'h0ABC, 1'b1, 15'h6ABC, 1'b0, 1'b0, 13'h0000, 1'b1},
    '{8'h38, 3'd1, 1'b1, 1'b0, 13'h0ABC, 1'b0, 15'h0000, 1'b1, 1'b0, 13'h0ABC, 1'b1},
    '{8'h18, 3'd1, 1'b0, 1'b1, 13'h0010, 1'b0, 15'h0000, 1'b0, 1'b0, 13'h0000, 1'b0},
    '{8'h20, 3'd1, 1'b0, 1'b1, 13'h1234, 1'b0, 15'h0000, 1'b1, 1'b1, 13'h1234, 1'b0},
    '{8'h18, 3'd2, 1'b1, 1'b0, 13'h0456, 1'b1, 15'h0456, 1'b0, 1'b0, 13'h0000, 1'b1},
    '{8'h10, 3'd4, 1'b1, 1'b0, 13'h1E42, 1'b1, 15'h5F42, 1'b0, 1'b0, 13'h0000, 1'b1},
    '{8'h30, 3'd4, 1'b1, 1'b0, 13'h00FF, 1'b0, 15'h0000, 1'b1, 1'b0, 13'h1FFF, 1'b1},
    '{8'h30, 3'd4, 1'b0, 1'b1, 13'h0007, 1'b0, 15'h0000, 1'b1, 1'b1, 13'h1F07, 1'b0},
    '{8'h08, 3'd4, 1'b0, 1'b1, 13'h0007, 1'b0, 15'h0000, 1'b0, 1'b0, 13'h0000, 1'b0},
    '{8'h00, 3'd3, 1'b1, 1'b0, 13'h0055, 1'b0, 15'h0000, 1'b0, 1'b0, 13'h0000, 1'b0},
    '{8'h18, 3'd2, 1'b0, 1'b1, 13'h0456, 1'b0, 15'h0000, 1'b0, 1'b0, 13'h0000, 1'b0}
  };
  localparam string VREQ [NV] = '{"R4", "R4", "R4", "R4", "R5", "R6", "R6",
                                  "R9", "R7", "R7", "R8", "R8", "R10", "R9"};

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    acc_region = 3'd0; acc_rd = 1'b0; acc_wr = 1'b0; acc_addr = '0;
    wr_data = '0; freeze_req = 1'b0; detach_req = 1'b0; attach_req = 1'b0;
  endtask

  // write a control byte; returns at the falling edge after the loading edge
  task automatic write_mode(input logic [7:0] m);
    @(negedge clk);
    idle();
    acc_region = 3'd3; acc_wr = 1'b1; wr_data = m;
    @(negedge clk);
    idle();
  endtask

  task automatic pulse_req(input logic fz, input logic dt, input logic at,
                           input logic wr, input logic [7:0] m);
    @(negedge clk);
    idle();
    freeze_req = fz; detach_req = dt; attach_req = at;
    if (wr) begin acc_region = 3'd3; acc_wr = 1'b1; wr_data = m; end
    @(negedge clk);
    idle();
  endtask

  // low-window read; returns {ram_cs, rom_cs, rom_addr[14:13]}
  task automatic probe_low(output logic [3:0] res);
    acc_region = 3'd1; acc_rd = 1'b1; acc_addr = 13'h0001;
    #1;
    res = {ram_cs, rom_cs, rom_addr[14:13]};
    idle();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [3:0] pr;
    idle();
    rst_n = 1'b0;
    #(CLK_PERIOD * 2 + 2);
    // R1 reset state
    check("R1", {game, exrom, freeze_release}, 3'b010);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {game, exrom, freeze_release}, 3'b010);

    // table walk
    for (int i = 0; i < NV; i++) begin
      write_mode(VEC[i].mode);
      acc_region = VEC[i].rgn; acc_rd = VEC[i].rd; acc_wr = VEC[i].wr;
      acc_addr = VEC[i].addr;
      #1;
      check(VREQ[i], {rom_cs, rom_addr, ram_cs, ram_we, ram_addr},
            {VEC[i].e_rom, VEC[i].e_rom_addr, VEC[i].e_ram, VEC[i].e_we, VEC[i].e_ram_addr});
      check("R12", rd_valid, VEC[i].e_valid);
      idle();
    end

    // R2 decode of the configuration lines
    write_mode(8'h03);
    check("R2", {game, exrom}, 2'b10);
    write_mode(8'h01);
    check("R2", {game, exrom}, 2'b11);
    write_mode(8'h02);
    check("R2", {game, exrom}, 2'b00);

    // R3 release pulse lasts one cycle
    write_mode(8'h40);
    check("R3", freeze_release, 1'b1);
    @(negedge clk);
    check("R3", freeze_release, 1'b0);
    write_mode(8'h00);
    check("R3", freeze_release, 1'b0);

    // R11 freeze beats a simultaneous write with bit 6 set: mode 35
    pulse_req(1'b1, 1'b0, 1'b0, 1'b1, 8'h58);
    check("R3", freeze_release, 1'b0);
    check("R11", {game, exrom}, 2'b10);
    probe_low(pr);
    check("R11", pr, 4'b1000);

    // R11 detach beats attach: mode 6
    pulse_req(1'b0, 1'b1, 1'b1, 1'b0, 8'h00);
    check("R11", {game, exrom}, 2'b00);
    probe_low(pr);
    check("R11", pr, 4'b0100);

    // R11 attach beats a write: mode 0
    write_mode(8'h19);
    pulse_req(1'b0, 1'b0, 1'b1, 1'b1, 8'h19);
    check("R11", {game, exrom}, 2'b01);
    probe_low(pr);
    check("R11", pr, 4'b0100);

    // R11 freeze beats detach
    pulse_req(1'b1, 1'b1, 1'b0, 1'b0, 8'h00);
    check("R11", {game, exrom}, 2'b10);

    // R1 asynchronous reset clears to 0
    write_mode(8'h39);
    #2;
    rst_n = 1'b0;
    #1;
    check("R1", {game, exrom}, 2'b01);
    @(negedge clk);
    rst_n = 1'b1;
    probe_low(pr);
    check("R1", pr, 4'b0100);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule